// File: doc/BRIEF.md
# Multi-Cycle Control Point Sequencer

This block is the controller of a small processor built around one shared adder and two shared buses: an address bus and a data bus. It reads the fields of the instruction register and two comparison flags from the datapath. For every cycle it drives the control points that steer sources onto the buses, set up the adder, and load the instruction register, the register file or the program counter. The register file, the adder, the memory and the PC incrementer are outside the block.

Each instruction takes exactly three cycles. The states are named ST_FETCH, ST_EXEC and ST_PCUPD. The transitions are: `fetch_done` takes ST_FETCH to ST_EXEC, `exec_done` takes ST_EXEC to ST_PCUPD, and `pc_done` takes ST_PCUPD back to ST_FETCH. A synchronous reset enters ST_FETCH from any state. ST_FETCH reads memory at the PC into the instruction register. ST_EXEC asserts the transfer set of the decoded instruction. ST_PCUPD loads the PC from the source that the instruction and the flags select. The supported forms are add, subtract, load word, store word, absolute jump, jump through register, branch on equal, and branch on negative. Any other encoding writes nothing and moves to the next sequential PC.

Top module: `mc_ctrl_sequencer`

## Requirements
- R1: While `rst` is high, the next clock edge sets `step` to 0 (ST_FETCH). After reset, `step` repeats the cycle 0 (fetch) → 1 (exec) → 2 (pc update) → 0.
- R2: In step 0 the only asserted control points are `pc_to_abus`, `mem_to_dbus` and `ir_load`, and `npc_sel` is 0.
- R3: Add (opcode 6'h00, funct 6'h21): in step 1 only `sum_to_dbus` and `reg_load` are asserted. `adder_comp`, `sext_sel` and `dest_rt` stay low, so the destination is rd.
- R4: Subtract (opcode 6'h00, funct 6'h23): in step 1 the outputs are those of R3, and `adder_comp` is also high.
- R5: Load word (opcode 6'h23): in step 1 only `sext_sel`, `sum_to_abus`, `mem_to_dbus`, `reg_load` and `dest_rt` are asserted.
- R6: Store word (opcode 6'h2B): in step 1 only `rt_to_dbus`, `sext_sel`, `sum_to_abus` and `mem_write` are asserted. `mem_write` is never high in any other case.
- R7: In step 2 the only asserted control point is `pc_load`. For add, subtract, load and store, `npc_sel` is 0 (incremented PC).
- R8: Branch on equal (opcode 6'h04): step 1 asserts only `adder_comp`. In step 2, `npc_sel` is 1 (branch target) when `eq_flag` is high and 0 otherwise.
- R9: Branch on negative (opcode 6'h01 with rt field 0): step 1 asserts nothing. In step 2, `npc_sel` is 1 when `neg_flag` is high and 0 otherwise. Opcode 6'h01 with any other rt value counts as unrecognised.
- R10: Absolute jump (opcode 6'h02): step 2 sets `npc_sel` to 2. Register jump (opcode 6'h00, funct 6'h08): step 2 sets `npc_sel` to 3. Neither form asserts anything in step 1.
- R11: An unrecognised encoding asserts nothing in step 1 and sets `npc_sel` to 0 in step 2.
- R12: At most one address-bus source and at most one data-bus source are active in any cycle. `ir_load` is high only in step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | 6 | Opcode field of the instruction register |
| ir_funct | input | 6 | Function field of the instruction register |
| ir_rt | input | 5 | rt field of the instruction register |
| eq_flag | input | 1 | Datapath flag: the two source registers are equal |
| neg_flag | input | 1 | Datapath flag: the rs register is negative |
| step | output | 2 | Current state: 0 fetch, 1 exec, 2 pc update |
| pc_to_abus | output | 1 | PC drives the address bus |
| sum_to_abus | output | 1 | Adder sum drives the address bus |
| mem_to_dbus | output | 1 | Memory read data drives the data bus |
| sum_to_dbus | output | 1 | Adder sum drives the data bus |
| rt_to_dbus | output | 1 | rt register value drives the data bus |
| adder_comp | output | 1 | Adder complements its B operand (subtract) |
| sext_sel | output | 1 | Adder B operand is the sign-extended immediate |
| reg_load | output | 1 | Register file write enable |
| dest_rt | output | 1 | Destination register is rt (low: rd) |
| mem_write | output | 1 | Memory write enable |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | PC load |
| npc_sel | output | 2 | Next PC source: 0 increment, 1 branch, 2 jump field, 3 register |

## Verification
The assertions assume that the instruction fields and the flags are stable from the fetch cycle through the PC update cycle. The assertions on store and on the bus sources relate the outputs to the decoded fields during that window. The bench holds all inputs fixed across the three cycles of each instruction and changes them only at a falling edge before the next fetch. It sweeps every opcode, every function code under opcode zero, every rt value under opcode one, and all four combinations of the flags. One reset is applied in the middle of an instruction, and it returns the machine to fetch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int OP_W = 6;
    localparam int FN_W = 6;
    localparam int RT_W = 5;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OP_REGIMM = 6'h01;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
    localparam logic [FN_W-1:0] FN_ADD   = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB   = 6'h23;
    localparam logic [FN_W-1:0] FN_JREG  = 6'h08;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_PCUPD = 2'd2
    } step_t;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_LOAD, K_STORE, K_JUMP, K_JREG, K_BEQ, K_BNEG
    } kind_t;

    typedef enum logic [1:0] {
        NPC_INC = 2'd0,
        NPC_BR  = 2'd1,
        NPC_JMP = 2'd2,
        NPC_REG = 2'd3
    } npc_t;

    typedef struct packed {
        logic pc_to_abus;
        logic sum_to_abus;
        logic mem_to_dbus;
        logic sum_to_dbus;
        logic rt_to_dbus;
        logic adder_comp;
        logic sext_sel;
        logic reg_load;
        logic dest_rt;
        logic mem_write;
        logic ir_load;
        logic pc_load;
        npc_t npc_sel;
    } ctl_t;
endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    input  logic [RT_W-1:0] rt,
    output kind_t           kind
);
    always_comb begin
        kind = K_NONE;
        case (opcode)
            OP_RTYPE: begin
                case (funct)
                    FN_ADD:  kind = K_ADD;
                    FN_SUB:  kind = K_SUB;
                    FN_JREG: kind = K_JREG;
                    default: kind = K_NONE;
                endcase
            end
            OP_REGIMM: kind = (rt == '0) ? K_BNEG : K_NONE;
            OP_JUMP:   kind = K_JUMP;
            OP_BEQ:    kind = K_BEQ;
            OP_LOAD:   kind = K_LOAD;
            OP_STORE:  kind = K_STORE;
            default:   kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/mcs_ctl.sv
module mcs_ctl
    import mcs_pkg::*;
(
    input  step_t step,
    input  kind_t kind,
    input  logic  eq_flag,
    input  logic  neg_flag,
    output ctl_t  ctl
);
    always_comb begin
        ctl = '0;
        unique case (step)
            ST_FETCH: begin
                ctl.pc_to_abus  = 1'b1;
                ctl.mem_to_dbus = 1'b1;
                ctl.ir_load     = 1'b1;
            end
            ST_EXEC: begin
                case (kind)
                    K_ADD, K_SUB: begin
                        ctl.sum_to_dbus = 1'b1;
                        ctl.reg_load    = 1'b1;
                        ctl.adder_comp  = (kind == K_SUB);
                    end
                    K_LOAD: begin
                        ctl.sext_sel    = 1'b1;
                        ctl.sum_to_abus = 1'b1;
                        ctl.mem_to_dbus = 1'b1;
                        ctl.reg_load    = 1'b1;
                        ctl.dest_rt     = 1'b1;
                    end
                    K_STORE: begin
                        ctl.rt_to_dbus  = 1'b1;
                        ctl.sext_sel    = 1'b1;
                        ctl.sum_to_abus = 1'b1;
                        ctl.mem_write   = 1'b1;
                    end
                    K_BEQ:   ctl.adder_comp = 1'b1;
                    default: ctl = '0;
                endcase
            end
            ST_PCUPD: begin
                ctl.pc_load = 1'b1;
                case (kind)
                    K_BEQ:   ctl.npc_sel = eq_flag  ? NPC_BR : NPC_INC;
                    K_BNEG:  ctl.npc_sel = neg_flag ? NPC_BR : NPC_INC;
                    K_JUMP:  ctl.npc_sel = NPC_JMP;
                    K_JREG:  ctl.npc_sel = NPC_REG;
                    default: ctl.npc_sel = NPC_INC;
                endcase
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_sequencer.sv
module mc_ctrl_sequencer
    import mcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] ir_opcode,
    input  logic [FN_W-1:0] ir_funct,
    input  logic [RT_W-1:0] ir_rt,
    input  logic            eq_flag,
    input  logic            neg_flag,
    output logic [1:0]      step,
    output logic            pc_to_abus,
    output logic            sum_to_abus,
    output logic            mem_to_dbus,
    output logic            sum_to_dbus,
    output logic            rt_to_dbus,
    output logic            adder_comp,
    output logic            sext_sel,
    output logic            reg_load,
    output logic            dest_rt,
    output logic            mem_write,
    output logic            ir_load,
    output logic            pc_load,
    output logic [1:0]      npc_sel
);
    step_t step_q, step_d;
    kind_t kind;
    ctl_t  ctl;

    always_comb begin
        unique case (step_q)
            ST_FETCH: step_d = ST_EXEC;   // fetch_done
            ST_EXEC:  step_d = ST_PCUPD;  // exec_done
            ST_PCUPD: step_d = ST_FETCH;  // pc_done
            default:  step_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_FETCH;
        else     step_q <= step_d;
    end

    mcs_decode u_decode (
        .opcode (ir_opcode),
        .funct  (ir_funct),
        .rt     (ir_rt),
        .kind   (kind)
    );

    mcs_ctl u_ctl (
        .step     (step_q),
        .kind     (kind),
        .eq_flag  (eq_flag),
        .neg_flag (neg_flag),
        .ctl      (ctl)
    );

    assign step        = step_q;
    assign pc_to_abus  = ctl.pc_to_abus;
    assign sum_to_abus = ctl.sum_to_abus;
    assign mem_to_dbus = ctl.mem_to_dbus;
    assign sum_to_dbus = ctl.sum_to_dbus;
    assign rt_to_dbus  = ctl.rt_to_dbus;
    assign adder_comp  = ctl.adder_comp;
    assign sext_sel    = ctl.sext_sel;
    assign reg_load    = ctl.reg_load;
    assign dest_rt     = ctl.dest_rt;
    assign mem_write   = ctl.mem_write;
    assign ir_load     = ctl.ir_load;
    assign pc_load     = ctl.pc_load;
    assign npc_sel     = ctl.npc_sel;

    a_r1_fetch_to_exec: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_FETCH) |=> (step_q == ST_EXEC));
    a_r1_exec_to_pcupd: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_EXEC) |=> (step_q == ST_PCUPD));
    a_r1_pcupd_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_PCUPD) |=> (step_q == ST_FETCH));
    a_r12_abus_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_to_abus, sum_to_abus}));
    a_r12_dbus_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_to_dbus, sum_to_dbus, rt_to_dbus}));
    a_r12_irload_fetch: assert property (@(posedge clk) disable iff (rst)
        ir_load |-> (step == 2'd0));
    a_r6_write_store_only: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> (step == 2'd1 && ir_opcode == OP_STORE));
    a_r7_pcload_update: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (step == 2'd2));
    a_r3_regload_exec: assert property (@(posedge clk) disable iff (rst)
        reg_load |-> (step == 2'd1 && !mem_write));
endmodule

// File: tb/mc_ctrl_sequencer_test.sv
module mc_ctrl_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ir_opcode = '0;
    logic [5:0] ir_funct = '0;
    logic [4:0] ir_rt = '0;
    logic       eq_flag = 1'b0;
    logic       neg_flag = 1'b0;
    logic [1:0] step;
    logic pc_to_abus, sum_to_abus, mem_to_dbus, sum_to_dbus, rt_to_dbus;
    logic adder_comp, sext_sel, reg_load, dest_rt, mem_write, ir_load, pc_load;
    logic [1:0] npc_sel;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_sequencer uut (
        .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .ir_funct(ir_funct),
        .ir_rt(ir_rt), .eq_flag(eq_flag), .neg_flag(neg_flag), .step(step),
        .pc_to_abus(pc_to_abus), .sum_to_abus(sum_to_abus),
        .mem_to_dbus(mem_to_dbus), .sum_to_dbus(sum_to_dbus),
        .rt_to_dbus(rt_to_dbus), .adder_comp(adder_comp), .sext_sel(sext_sel),
        .reg_load(reg_load), .dest_rt(dest_rt), .mem_write(mem_write),
        .ir_load(ir_load), .pc_load(pc_load), .npc_sel(npc_sel)
    );

    // bit order: pcA sumA memD sumD rtD comp sext regld destrt wrt irld pcld npc[1:0]
    function automatic logic [13:0] outs();
        return {pc_to_abus, sum_to_abus, mem_to_dbus, sum_to_dbus, rt_to_dbus,
                adder_comp, sext_sel, reg_load, dest_rt, mem_write, ir_load,
                pc_load, npc_sel};
    endfunction

    function automatic logic [13:0] model(int ph, int op, int fn, int rt,
                                          bit eq, bit ng, output string tag);
        logic [13:0] v = '0;
        tag = "R11";
        if (ph == 0) begin
            v[13] = 1; v[11] = 1; v[3] = 1; tag = "R2";
        end else if (ph == 1) begin
            if (op == 0 && fn == 'h21) begin v[10] = 1; v[6] = 1; tag = "R3"; end
            else if (op == 0 && fn == 'h23) begin v[10] = 1; v[6] = 1; v[8] = 1; tag = "R4"; end
            else if (op == 'h23) begin v[7] = 1; v[12] = 1; v[11] = 1; v[6] = 1; v[5] = 1; tag = "R5"; end
            else if (op == 'h2B) begin v[9] = 1; v[7] = 1; v[12] = 1; v[4] = 1; tag = "R6"; end
            else if (op == 'h04) begin v[8] = 1; tag = "R8"; end
            else if (op == 1 && rt == 0) tag = "R9";
            else if (op == 2 || (op == 0 && fn == 'h08)) tag = "R10";
        end else begin
            v[2] = 1;
            if ((op == 0 && (fn == 'h21 || fn == 'h23)) || op == 'h23 || op == 'h2B) tag = "R7";
            else if (op == 'h04) begin v[1:0] = eq ? 2'd1 : 2'd0; tag = "R8"; end
            else if (op == 1 && rt == 0) begin v[1:0] = ng ? 2'd1 : 2'd0; tag = "R9"; end
            else if (op == 2) begin v[1:0] = 2'd2; tag = "R10"; end
            else if (op == 0 && fn == 'h08) begin v[1:0] = 2'd3; tag = "R10"; end
        end
        return v;
    endfunction

    task automatic check_vec(string tag, logic [13:0] got, logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s outputs got %b expected %b (op %h fn %h rt %0d)",
                     tag, got, exp, ir_opcode, ir_funct, ir_rt);
        end
    endtask

    task automatic check_step(int exp);
        checks++;
        if (step !== 2'(exp)) begin
            fails++;
            $display("FAIL R1 step got %0d expected %0d", step, exp);
        end
    endtask

    // Entered just after a falling edge with the machine in fetch.
    task automatic run_instr(int op, int fn, int rt, bit eq, bit ng);
        string tag;
        logic [13:0] e;
        ir_opcode = 6'(op); ir_funct = 6'(fn); ir_rt = 5'(rt);
        eq_flag = eq; neg_flag = ng;
        #1;
        for (int ph = 0; ph < 3; ph++) begin
            check_step(ph);
            e = model(ph, op, fn, rt, eq, ng, tag);
            check_vec(tag, outs(), e);
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_step(0);  // R1 reset state
        check_vec("R1", outs(), 14'b10100000001000);
        rst = 1'b0;

        for (int op = 0; op < 64; op++) begin
            if (op == 0) begin
                for (int fn = 0; fn < 64; fn++)
                    for (int f = 0; f < 4; f++) run_instr(op, fn, 0, f[0], f[1]);
            end else if (op == 1) begin
                for (int rt = 0; rt < 32; rt++)
                    for (int f = 0; f < 4; f++) run_instr(op, 0, rt, f[0], f[1]);
            end else begin
                for (int f = 0; f < 4; f++) run_instr(op, op ^ 5, op & 31, f[0], f[1]);
            end
        end

        // R1: reset in the middle of an instruction returns to fetch
        ir_opcode = 6'h00; ir_funct = 6'h21;
        @(posedge clk); @(negedge clk);
        check_step(1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check_step(0);
        rst = 1'b0;
        run_instr(6'h2B, 0, 3, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule